// File: doc/BRIEF.md
# Clock, Reset and Ready Synchronizer

This block supports a processor subsystem from a single fast input clock. A six-phase state machine running on that clock produces two registered clock waveforms in the input-clock domain. The core clock runs at one third of the input rate and is high for one input cycle in three. The peripheral clock runs at one sixth of the input rate with a 50% duty cycle. The input clock is also passed straight through as an oscillator output, so other units of the same kind can share it.

The machine has seven named states: `HOLD`, then `PH0` through `PH5`. From `HOLD` it goes to `PH0`, then steps `PH0`→`PH1`→`PH2`→`PH3`→`PH4`→`PH5`→`PH0` (the wrap transition). From any state it goes to `HOLD` whenever the phase-align input is sampled high. Unused encodings recover to `PH0`. The machine powers up in `HOLD`, so the clocks start without a reset. The core clock is high in `PH0` and `PH3`. The peripheral clock is high in `PH0`, `PH1` and `PH2`.

An active-low asynchronous reset request passes through a synchronizer chain. The result is loaded into the active-high system reset only on edges where the core clock rises, so the reset changes on core-clock boundaries. While the machine sits in `HOLD` there is no boundary, and the reset output keeps its value. Two ready requests, each qualified by its own active-low select, are ORed together. The combined request is then passed through one or two flop stages, chosen at run time, to form the ready output.

Top module: `clk_rst_rdy_gen`

## Requirements
- R1: `core_clk` repeats the pattern high, low, low on consecutive input-clock cycles, starting with the high cycle in `PH0`.
- R2: `periph_clk` repeats three high cycles then three low cycles. Each rising edge of `periph_clk` falls in the same cycle as a rising edge of `core_clk`.
- R3: `osc_pass` equals `clk_in` at all times.
- R4: While `phase_align` is sampled high, both `core_clk` and `periph_clk` are low from the next cycle on. On the first edge that samples `phase_align` low, both go high together, and the R1/R2 patterns restart from that cycle.
- R5: `sys_reset` is active high. After `arst_req_n` goes low, `sys_reset` rises 3 to 5 input-clock edges later (two synchronizer stages plus alignment), and on an edge where `core_clk` rises.
- R6: After `arst_req_n` returns high, `sys_reset` falls 3 to 5 edges later, again on a `core_clk` rising edge. `sys_reset` never changes on any other edge.
- R7: The combined ready request is `(rdy_a AND NOT sel_a_n) OR (rdy_b AND NOT sel_b_n)`. A ready input whose select is high has no effect on `ready_out`.
- R8: With `one_stage` = 1, `ready_out` shows the combined request as sampled at the previous edge.
- R9: With `one_stage` = 0, `ready_out` shows the combined request as sampled two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock for all logic |
| arst_req_n | input | 1 | Asynchronous reset request, active low |
| phase_align | input | 1 | Holds and restarts the divider phase; tie low if unused |
| rdy_a | input | 1 | First ready request |
| sel_a_n | input | 1 | Active-low qualifier for `rdy_a` |
| rdy_b | input | 1 | Second ready request |
| sel_b_n | input | 1 | Active-low qualifier for `rdy_b` |
| one_stage | input | 1 | 1: one synchronizer stage on ready; 0: two stages |
| osc_pass | output | 1 | Input clock passed through |
| core_clk | output | 1 | Divide-by-3 clock, one-third high |
| periph_clk | output | 1 | Divide-by-6 clock, 50% duty |
| sys_reset | output | 1 | Synchronized reset, active high |
| ready_out | output | 1 | Synchronized, qualified ready |

## Verification
The bench builds the block with its default reset chain depth of two stages. With that depth, the whole 3-to-5 edge window for both reset edges can be measured against the six-phase cycle. Because `one_stage` is a run-time input rather than a parameter, both ready latencies are exercised in a single build. The bench pulses `phase_align` to place the divider at a known phase before it checks the clock patterns cycle by cycle.

// File: rtl/crg_pkg.sv
package crg_pkg;

    localparam int CORE_DIV   = 3;
    localparam int PERIPH_DIV = 2 * CORE_DIV;
    localparam int PH_W       = $clog2(PERIPH_DIV + 2);

    // HOLD is encoding zero, so a two-state register powers up there.
    typedef enum bit [PH_W-1:0] {
        HOLD = 0,
        PH0  = 1,
        PH1  = 2,
        PH2  = 3,
        PH3  = 4,
        PH4  = 5,
        PH5  = 6
    } phase_e;

    function automatic bit core_high(input phase_e p);
        return (p == PH0) || (p == PH3);
    endfunction

    function automatic bit periph_high(input phase_e p);
        return (p == PH0) || (p == PH1) || (p == PH2);
    endfunction

endpackage

// File: rtl/crg_divider.sv
module crg_divider
    import crg_pkg::*;
(
    input  logic clk,
    input  logic hold,
    output logic core_o,
    output logic periph_o,
    output logic boundary_o
);

    phase_e st;
    phase_e nxt;
    bit     core_r;
    bit     periph_r;
    bit     started;

    // Next-state process
    always_comb begin
        if (hold) begin
            nxt = HOLD;
        end else begin
            unique case (st)
                HOLD:    nxt = PH0;
                PH0:     nxt = PH1;
                PH1:     nxt = PH2;
                PH2:     nxt = PH3;
                PH3:     nxt = PH4;
                PH4:     nxt = PH5;
                PH5:     nxt = PH0;
                default: nxt = PH0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        st <= nxt;
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk) begin
        core_r   <= core_high(nxt);
        periph_r <= periph_high(nxt);
        started  <= 1'b1;
    end

    assign core_o     = core_r;
    assign periph_o   = periph_r;
    assign boundary_o = core_high(nxt);

    assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!started)
        hold |=> (!core_r && !periph_r));

    assert_core_third_R1: assert property (@(posedge clk) disable iff (hold)
        $rose(core_r) |=> !core_r ##1 !core_r);

    assert_periph_align_R2: assert property (@(posedge clk) disable iff (hold)
        $rose(periph_r) |-> core_r);

    assert_periph_half_R2: assert property (@(posedge clk) disable iff (hold)
        $rose(periph_r) |=> periph_r ##1 periph_r);

endmodule

// File: rtl/crg_rst_sync.sv
module crg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    output logic rst_o
);

    bit [STAGES-1:0] chain;
    bit              rst_r;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= ~arst_n;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= chain[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (load) rst_r <= chain[STAGES-1];
    end

    assign rst_o = rst_r;

endmodule

// File: rtl/crg_ready.sv
module crg_ready (
    input  logic clk,
    input  logic rdy_a,
    input  logic sel_a_n,
    input  logic rdy_b,
    input  logic sel_b_n,
    input  logic one_stage,
    output logic ready_o
);

    logic     raw;
    bit       s1;
    bit       s2;
    bit [1:0] age;

    assign raw = (rdy_a & ~sel_a_n) | (rdy_b & ~sel_b_n);

    always_ff @(posedge clk) begin
        s1 <= raw;
        s2 <= s1;
        if (age != 2'd3) age <= age + 2'd1;
    end

    assign ready_o = one_stage ? s1 : s2;

    assert_one_stage_R8: assert property (@(posedge clk) disable iff (age != 2'd3)
        one_stage |-> ready_o == $past((rdy_a && !sel_a_n) || (rdy_b && !sel_b_n)));

    assert_two_stage_R9: assert property (@(posedge clk) disable iff (age != 2'd3)
        !one_stage |-> ready_o == $past((rdy_a && !sel_a_n) || (rdy_b && !sel_b_n), 2));

endmodule

// File: rtl/clk_rst_rdy_gen.sv
module clk_rst_rdy_gen #(
    parameter int RST_STAGES = 2
) (
    input  logic clk_in,
    input  logic arst_req_n,
    input  logic phase_align,
    input  logic rdy_a,
    input  logic sel_a_n,
    input  logic rdy_b,
    input  logic sel_b_n,
    input  logic one_stage,
    output logic osc_pass,
    output logic core_clk,
    output logic periph_clk,
    output logic sys_reset,
    output logic ready_out
);

    logic boundary;

    assign osc_pass = clk_in;

    crg_divider u_div (
        .clk        (clk_in),
        .hold       (phase_align),
        .core_o     (core_clk),
        .periph_o   (periph_clk),
        .boundary_o (boundary)
    );

    crg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk    (clk_in),
        .arst_n (arst_req_n),
        .load   (boundary),
        .rst_o  (sys_reset)
    );

    crg_ready u_rdy (
        .clk       (clk_in),
        .rdy_a     (rdy_a),
        .sel_a_n   (sel_a_n),
        .rdy_b     (rdy_b),
        .sel_b_n   (sel_b_n),
        .one_stage (one_stage),
        .ready_o   (ready_out)
    );

    // Covers both edges of the reset output (R5 and R6)
    assert_rst_boundary_R5: assert property (@(posedge clk_in) disable iff (phase_align)
        !$stable(sys_reset) |-> $rose(core_clk));

endmodule

// File: tb/sim_clk_rst_rdy_gen.sv
module sim_clk_rst_rdy_gen;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic arst_req_n, phase_align, rdy_a, sel_a_n, rdy_b, sel_b_n, one_stage;
    logic osc_pass, core_clk, periph_clk, sys_reset, ready_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    clk_rst_rdy_gen u0 (
        .clk_in      (clk),
        .arst_req_n  (arst_req_n),
        .phase_align (phase_align),
        .rdy_a       (rdy_a),
        .sel_a_n     (sel_a_n),
        .rdy_b       (rdy_b),
        .sel_b_n     (sel_b_n),
        .one_stage   (one_stage),
        .osc_pass    (osc_pass),
        .core_clk    (core_clk),
        .periph_clk  (periph_clk),
        .sys_reset   (sys_reset),
        .ready_out   (ready_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        repeat (8) tick();
        check("R5", "sys_reset held by request", int'(sys_reset), 1);
    endtask

    task automatic t_osc();
        check("R3", "osc_pass low phase", int'(osc_pass), int'(clk));
        @(posedge clk);
        #2;
        check("R3", "osc_pass high phase", int'(osc_pass), int'(clk));
        @(negedge clk);
    endtask

    task automatic t_rst_edge(input string req, input logic lvl);
        int n = 0;
        arst_req_n = lvl;
        for (int i = 0; i < 10; i++) begin
            tick();
            n++;
            if (sys_reset == !lvl) break;
        end
        check(req, "reset latency within 3..5", int'(n >= 3 && n <= 5), 1);
        check(req, "reset changes with core_clk high", int'(core_clk), 1);
    endtask

    task automatic t_sync();
        phase_align = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R4", "core_clk held low", int'(core_clk), 0);
            check("R4", "periph_clk held low", int'(periph_clk), 0);
        end
        phase_align = 1'b0;
        for (int k = 0; k < 12; k++) begin
            tick();
            check("R1", "core_clk pattern", int'(core_clk), int'(k % 3 == 0));
            check("R2", "periph_clk pattern", int'(periph_clk), int'(k % 6 < 3));
        end
    endtask

    task automatic set_rdy(input logic ra, input logic sa, input logic rb, input logic sb);
        rdy_a = ra; sel_a_n = sa; rdy_b = rb; sel_b_n = sb;
    endtask

    task automatic t_gate();
        one_stage = 1'b1;
        set_rdy(1, 1, 1, 1); repeat (3) tick();
        check("R7", "both deselected", int'(ready_out), 0);
        set_rdy(1, 0, 0, 1); repeat (3) tick();
        check("R7", "a selected", int'(ready_out), 1);
        set_rdy(0, 0, 1, 0); repeat (3) tick();
        check("R7", "b selected", int'(ready_out), 1);
        set_rdy(1, 1, 0, 0); repeat (3) tick();
        check("R7", "a ignored while deselected", int'(ready_out), 0);
        set_rdy(0, 1, 1, 0); repeat (3) tick();
        check("R7", "b alone", int'(ready_out), 1);
    endtask

    task automatic t_one_stage();
        one_stage = 1'b1;
        set_rdy(0, 1, 0, 1); repeat (3) tick();
        set_rdy(1, 0, 0, 1);
        tick();
        check("R8", "rise after one edge", int'(ready_out), 1);
        set_rdy(1, 1, 0, 1);
        tick();
        check("R8", "fall after one edge", int'(ready_out), 0);
    endtask

    task automatic t_two_stage();
        one_stage = 1'b0;
        set_rdy(0, 1, 0, 1); repeat (3) tick();
        set_rdy(0, 1, 1, 0);
        tick();
        check("R9", "not yet after one edge", int'(ready_out), 0);
        tick();
        check("R9", "rise after two edges", int'(ready_out), 1);
        set_rdy(0, 1, 0, 0);
        tick();
        check("R9", "still high after one edge", int'(ready_out), 1);
        tick();
        check("R9", "fall after two edges", int'(ready_out), 0);
    endtask

    initial begin
        arst_req_n = 1'b0; phase_align = 1'b0; one_stage = 1'b1;
        rdy_a = 1'b0; sel_a_n = 1'b1; rdy_b = 1'b0; sel_b_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_osc();
        t_rst_edge("R6", 1'b1);
        repeat (7) tick();
        t_rst_edge("R5", 1'b0);
        t_rst_edge("R6", 1'b1);
        t_sync();
        t_gate();
        t_one_stage();
        t_two_stage();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule